// File: doc/BRIEF.md
# Three-Phase Gate Interlock and Fault Logic

This block sits between a PWM generator and the gate drivers of a three-phase bridge with a brake switch. It receives seven active-low switch commands: an upper and a lower command for each phase, plus one for the brake. It brings them into the clock domain and turns them into active-high gate enables.

The block refuses any command pattern that would turn on both switches of one leg at once. When that happens, it shuts off both switches of the leg and latches a fault. The latch releases only after each of the two commands of that leg has had a fresh falling edge. The block also takes per-switch short-circuit sense bits and per-phase current-limit comparator bits. Each of these sets a flag that clears on the next pulse, so protection works pulse by pulse.

Faults are reported on an active-low output, and so are current-limit warnings. Both outputs suit pulled-up open-collector pins.

Top module: `gate_guard_top`

## Requirements
- R1: Commands are active low. A LOW command turns its gate enable on, and a HIGH command turns it off. A command change reaches its gate enable at the third rising clock edge after the change: two synchronizer stages plus the output register.
- R2: While `rst` is high at a rising edge, all gate enables go to 0 and both `fault_n` and `warn_n` go to 1. The synchronizer treats every command as HIGH (off).
- R3: If the upper and lower commands of one phase are both LOW in the synchronized sample, both gates of that phase are off. `fault_n` goes low at the same edge at which the gates would otherwise have turned on.
- R4: A shoot-through latch holds both gates of its phase off and keeps `fault_n` low. It releases at the edge that sees the later of the two required falling edges: one of the upper command and one of the lower command, each occurring after the latch was set. A rising edge alone never releases it.
- R5: A sense bit of 1 in `sc_sense` at a rising edge turns off the gate of that one switch at that edge and drives `fault_n` low. Bit 2p is the upper switch of phase p, and bit 2p+1 is the lower switch of phase p. Other gates are not affected.
- R6: A short-circuit flag stays set until the next falling edge of that switch's own synchronized command. From that edge on, the gate follows its command again and the flag no longer holds `fault_n` low.
- R7: The brake gate follows `brk_n` with the R1 latency. Shoot-through detection and short-circuit sensing have no effect on it.
- R8: A 1 on `ilim[p]` at a rising edge drives `warn_n` low at that edge. The warning holds until the next falling edge of either command of phase p. It never turns off a gate.
- R9: `fault_n` is low exactly when at least one shoot-through latch or short-circuit flag is set.
- R10: If a set condition arrives at the same edge as the clearing edge, the flag stays set. Set conditions are a sense bit and a simultaneous-on command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_n | input | NPH | Upper-switch commands, active low, one per phase |
| dn_n | input | NPH | Lower-switch commands, active low, one per phase |
| brk_n | input | 1 | Brake command, active low |
| sc_sense | input | 2*NPH | Short-circuit sense, bit 2p upper and 2p+1 lower of phase p |
| ilim | input | NPH | Current-limit comparator per phase |
| gate_up | output | NPH | Upper gate enables, active high |
| gate_dn | output | NPH | Lower gate enables, active high |
| gate_brk | output | 1 | Brake gate enable, active high |
| fault_n | output | 1 | Fault flag, active low |
| warn_n | output | 1 | Current-limit warning, active low |

## Verification
Directed sequences first check the three-edge latency of a single command. They then check a shoot-through release that requires both fresh falling edges, so that one edge alone is told apart from the full release sequence. They also cover a short-circuit pulse that must kill only its own switch, and a sense bit timed onto the clearing edge so that set priority is separated from clear priority.

Random toggling of all seven commands, with sparse sense and limit bits, then compares every output each cycle with a bench model. This run covers latches that overlap across phases, as well as brake activity during faults.

// File: rtl/gate_guard_pkg.sv
package gate_guard_pkg;

    // Level of a command line when no switch is requested
    localparam logic CMD_IDLE = 1'b1;

    // Per-leg view of the synchronized commands
    typedef struct packed {
        logic hi_on;
        logic lo_on;
        logic hi_fall;
        logic lo_fall;
    } leg_cmd_t;

    // One bit per switch of a leg
    typedef struct packed {
        logic hi;
        logic lo;
    } leg_pair_t;

    // Build the leg view from current and previous synchronized levels
    function automatic leg_cmd_t make_leg_cmd(logic hi_lvl, logic hi_prv,
                                              logic lo_lvl, logic lo_prv);
        leg_cmd_t c;
        c.hi_on   = ~hi_lvl;
        c.lo_on   = ~lo_lvl;
        c.hi_fall = hi_prv & ~hi_lvl;
        c.lo_fall = lo_prv & ~lo_lvl;
        return c;
    endfunction

endpackage

// File: rtl/gate_guard_sync.sv
module gate_guard_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prv
);
    import gate_guard_pkg::*;

    localparam logic [W-1:0] IDLE_VEC = {W{CMD_IDLE}};

    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= IDLE_VEC;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= IDLE_VEC;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prv <= IDLE_VEC;
        else     prv <= chain[STAGES-1];
    end

    assign lvl = chain[STAGES-1];

endmodule

// File: rtl/gate_guard_leg.sv
module gate_guard_leg
    import gate_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  leg_cmd_t  cmd,
    input  leg_pair_t sense,
    input  logic      ilim,
    output logic      gate_hi,
    output logic      gate_lo,
    output logic      il_nx,
    output leg_pair_t sc_nx,
    output logic      cl_nx
);
    logic      il_q;
    leg_pair_t seen_q;
    leg_pair_t sc_q;
    logic      cl_q;

    logic      both_on;
    logic      release_now;
    leg_pair_t seen_nx;

    always_comb begin
        both_on     = cmd.hi_on & cmd.lo_on;
        release_now = il_q & (seen_q.hi | cmd.hi_fall) & (seen_q.lo | cmd.lo_fall);
        il_nx       = both_on | (il_q & ~release_now);

        if (!il_q || release_now) begin
            seen_nx = '0;
        end else begin
            seen_nx.hi = seen_q.hi | cmd.hi_fall;
            seen_nx.lo = seen_q.lo | cmd.lo_fall;
        end

        sc_nx.hi = sense.hi | (sc_q.hi & ~cmd.hi_fall);
        sc_nx.lo = sense.lo | (sc_q.lo & ~cmd.lo_fall);

        cl_nx    = ilim | (cl_q & ~(cmd.hi_fall | cmd.lo_fall));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            il_q    <= 1'b0;
            seen_q  <= '0;
            sc_q    <= '0;
            cl_q    <= 1'b0;
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
        end else begin
            il_q    <= il_nx;
            seen_q  <= seen_nx;
            sc_q    <= sc_nx;
            cl_q    <= cl_nx;
            gate_hi <= cmd.hi_on & ~il_nx & ~sc_nx.hi;
            gate_lo <= cmd.lo_on & ~il_nx & ~sc_nx.lo;
        end
    end

    // R3
    no_shoot_chk: assert property (@(posedge clk) disable iff (rst)
        !(gate_hi && gate_lo));

    // R3
    latch_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.hi_on && cmd.lo_on) |=> (il_q && !gate_hi && !gate_lo));

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (il_q && !cmd.hi_fall && !cmd.lo_fall) |=> il_q);

    // R5
    sc_kill_chk: assert property (@(posedge clk) disable iff (rst)
        sense.lo |=> (!gate_lo && sc_q.lo));

    // R6
    sc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sc_q.hi && !cmd.hi_fall) |=> (sc_q.hi && !gate_hi));

    // R8
    warn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cl_q && !cmd.hi_fall && !cmd.lo_fall) |=> cl_q);

endmodule

// File: rtl/gate_guard_top.sv
module gate_guard_top
    import gate_guard_pkg::*;
#(
    parameter int NPH         = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPH-1:0]   up_n,
    input  logic [NPH-1:0]   dn_n,
    input  logic             brk_n,
    input  logic [2*NPH-1:0] sc_sense,
    input  logic [NPH-1:0]   ilim,
    output logic [NPH-1:0]   gate_up,
    output logic [NPH-1:0]   gate_dn,
    output logic             gate_brk,
    output logic             fault_n,
    output logic             warn_n
);
    localparam int CW = 2*NPH + 1;
    localparam int BI = 2*NPH;

    logic [CW-1:0] s_lvl;
    logic [CW-1:0] s_prv;

    gate_guard_sync #(.W(CW), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({brk_n, dn_n, up_n}),
        .lvl (s_lvl),
        .prv (s_prv)
    );

    logic [NPH-1:0] il_nx;
    logic [NPH-1:0] cl_nx;
    leg_pair_t      sc_nx [NPH];
    logic [NPH-1:0] sc_any;

    genvar p;
    generate
        for (p = 0; p < NPH; p++) begin : g_leg
            leg_cmd_t  lc;
            leg_pair_t ls;

            assign lc = make_leg_cmd(s_lvl[p], s_prv[p], s_lvl[NPH+p], s_prv[NPH+p]);
            assign ls.hi = sc_sense[2*p];
            assign ls.lo = sc_sense[2*p+1];

            gate_guard_leg u_leg (
                .clk     (clk),
                .rst     (rst),
                .cmd     (lc),
                .sense   (ls),
                .ilim    (ilim[p]),
                .gate_hi (gate_up[p]),
                .gate_lo (gate_dn[p]),
                .il_nx   (il_nx[p]),
                .sc_nx   (sc_nx[p]),
                .cl_nx   (cl_nx[p])
            );

            assign sc_any[p] = sc_nx[p].hi | sc_nx[p].lo;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_brk <= 1'b0;
            fault_n  <= 1'b1;
            warn_n   <= 1'b1;
        end else begin
            gate_brk <= ~s_lvl[BI];
            fault_n  <= ~(|il_nx | |sc_any);
            warn_n   <= ~(|cl_nx);
        end
    end

    // R7
    brake_on_chk: assert property (@(posedge clk) disable iff (rst)
        (!s_lvl[BI] && !rst) |=> gate_brk);

    // R5
    fault_sc_chk: assert property (@(posedge clk) disable iff (rst)
        (|sc_sense) |=> !fault_n);

    // R8
    warn_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|ilim) |=> !warn_n);

endmodule

// File: tb/tb_gate_guard_top.sv
module tb_gate_guard_top;
    localparam int NPH    = 3;
    localparam int CLK_NS = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NPH-1:0]   up_n = '1;
    logic [NPH-1:0]   dn_n = '1;
    logic             brk_n = 1'b1;
    logic [2*NPH-1:0] sc_sense = '0;
    logic [NPH-1:0]   ilim = '0;
    logic [NPH-1:0]   gate_up;
    logic [NPH-1:0]   gate_dn;
    logic             gate_brk;
    logic             fault_n;
    logic             warn_n;

    gate_guard_top #(.NPH(NPH)) dut (
        .clk(clk), .rst(rst), .up_n(up_n), .dn_n(dn_n), .brk_n(brk_n),
        .sc_sense(sc_sense), .ilim(ilim), .gate_up(gate_up), .gate_dn(gate_dn),
        .gate_brk(gate_brk), .fault_n(fault_n), .warn_n(warn_n)
    );

    always #(CLK_NS/2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Bench model state
    logic [NPH-1:0] h1 = '1, h2 = '1, hv = '1;
    logic [NPH-1:0] l1 = '1, l2 = '1, lv = '1;
    logic b1 = 1, b2 = 1;
    logic [NPH-1:0] m_il = '0, m_sh = '0, m_sl = '0, m_cl = '0;
    logic [NPH-1:0] m_sch = '0, m_scl = '0;
    logic [NPH-1:0] m_gu = '0, m_gd = '0;
    logic m_gb = 0, m_fn = 1, m_wn = 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_advance();
        logic onh, onl, fh, fl, rel, scx_h, scx_l;
        if (rst) begin
            h1 = '1; h2 = '1; hv = '1; l1 = '1; l2 = '1; lv = '1; b1 = 1; b2 = 1;
            m_il = '0; m_sh = '0; m_sl = '0; m_cl = '0; m_sch = '0; m_scl = '0;
            m_gu = '0; m_gd = '0; m_gb = 0; m_fn = 1; m_wn = 1;
            return;
        end
        for (int p = 0; p < NPH; p++) begin
            onh = ~h2[p]; onl = ~l2[p];
            fh  = hv[p] & ~h2[p]; fl = lv[p] & ~l2[p];
            rel = m_il[p] & (m_sh[p] | fh) & (m_sl[p] | fl);
            if (!m_il[p] || rel) begin
                m_sh[p] = 0; m_sl[p] = 0;
            end else begin
                m_sh[p] = m_sh[p] | fh; m_sl[p] = m_sl[p] | fl;
            end
            m_il[p]  = (onh & onl) | (m_il[p] & ~rel);
            scx_h    = sc_sense[2*p]   | (m_sch[p] & ~fh);
            scx_l    = sc_sense[2*p+1] | (m_scl[p] & ~fl);
            m_sch[p] = scx_h; m_scl[p] = scx_l;
            m_cl[p]  = ilim[p] | (m_cl[p] & ~(fh | fl));
            m_gu[p]  = onh & ~m_il[p] & ~scx_h;
            m_gd[p]  = onl & ~m_il[p] & ~scx_l;
        end
        m_gb = ~b2;
        m_fn = ~(|m_il | |m_sch | |m_scl);
        m_wn = ~(|m_cl);
        hv = h2; h2 = h1; h1 = up_n;
        lv = l2; l2 = l1; l1 = dn_n;
        b2 = b1; b1 = brk_n;
    endtask

    task automatic compare_model();
        check(gate_up == m_gu, "R3 upper gates", gate_up, m_gu);
        check(gate_dn == m_gd, "R3 lower gates", gate_dn, m_gd);
        check(gate_brk == m_gb, "R7 brake gate", gate_brk, m_gb);
        check(fault_n == m_fn, "R9 fault_n", fault_n, m_fn);
        check(warn_n == m_wn, "R8 warn_n", warn_n, m_wn);
    endtask

    task automatic step();
        model_advance();
        @(negedge clk);
        compare_model();
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2718));
        @(negedge clk);
        steps(3);
        rst = 0;
        step();
        // R2 reset state
        check(gate_up == 0 && gate_dn == 0 && !gate_brk, "R2 gates after reset",
              {gate_up, gate_dn, gate_brk}, 0);
        check(fault_n && warn_n, "R2 flags after reset", {fault_n, warn_n}, 3);

        // R1 latency of lower phase 0
        dn_n[0] = 0;
        steps(2);
        check(gate_dn[0] == 0, "R1 not yet on after two edges", gate_dn[0], 0);
        step();
        check(gate_dn[0] == 1, "R1 on at third edge", gate_dn[0], 1);

        // R3 shoot-through on phase 0
        up_n[0] = 0;
        steps(3);
        check(gate_up[0] == 0 && gate_dn[0] == 0, "R3 both off", {gate_up[0], gate_dn[0]}, 0);
        check(fault_n == 0, "R3 fault asserted", fault_n, 0);

        // R4 release needs both fresh falls
        up_n[0] = 1; dn_n[0] = 1; steps(4);
        check(fault_n == 0, "R4 rise alone keeps latch", fault_n, 0);
        up_n[0] = 0; steps(4);
        check(fault_n == 0 && gate_up[0] == 0, "R4 one fall keeps latch", {fault_n, gate_up[0]}, 0);
        up_n[0] = 1; steps(4);
        dn_n[0] = 0; steps(4);
        check(fault_n == 1, "R4 later fall releases", fault_n, 1);
        check(gate_dn[0] == 1, "R4 gate resumes", gate_dn[0], 1);

        // R5 short circuit on lower switch of phase 0, phase 1 upper on
        up_n[1] = 0; steps(4);
        sc_sense[1] = 1; step();
        sc_sense[1] = 0;
        check(gate_dn[0] == 0 && fault_n == 0, "R5 switch killed", {gate_dn[0], fault_n}, 0);
        check(gate_up[1] == 1, "R5 other gate unaffected", gate_up[1], 1);

        // R6 flag holds until next pulse of that switch
        steps(4);
        check(gate_dn[0] == 0 && fault_n == 0, "R6 held while command stays low", {gate_dn[0], fault_n}, 0);
        dn_n[0] = 1; steps(4);
        dn_n[0] = 0; steps(4);
        check(gate_dn[0] == 1 && fault_n == 1, "R6 cleared by next pulse", {gate_dn[0], fault_n}, 3);

        // R8 current-limit warning on phase 1
        ilim[1] = 1; step();
        ilim[1] = 0;
        check(warn_n == 0, "R8 warning asserted", warn_n, 0);
        check(gate_up[1] == 1, "R8 gate stays on", gate_up[1], 1);
        up_n[1] = 1; steps(4);
        check(warn_n == 0, "R8 rise does not clear", warn_n, 0);
        up_n[1] = 0; steps(4);
        check(warn_n == 1, "R8 next fall clears", warn_n, 1);

        // R7 brake during fault
        brk_n = 0; sc_sense[0] = 1; step(); sc_sense[0] = 0; steps(3);
        check(gate_brk == 1, "R7 brake unaffected by fault", gate_brk, 1);
        brk_n = 1; steps(3);
        check(gate_brk == 0, "R7 brake off", gate_brk, 0);

        // R10 sense on the clearing edge
        dn_n[0] = 1; steps(4);
        dn_n[0] = 0; steps(2);
        sc_sense[1] = 1; step();
        sc_sense[1] = 0;
        check(gate_dn[0] == 0 && fault_n == 0, "R10 set wins over clear", {gate_dn[0], fault_n}, 0);
        steps(4);
        check(gate_dn[0] == 0, "R10 flag still held", gate_dn[0], 0);

        // Random run
        for (int c = 0; c < 4000; c++) begin
            for (int p = 0; p < NPH; p++) begin
                if ($urandom % 5 == 0) up_n[p] = ~up_n[p];
                if ($urandom % 5 == 0) dn_n[p] = ~dn_n[p];
                ilim[p] = ($urandom % 25 == 0);
            end
            if ($urandom % 6 == 0) brk_n = ~brk_n;
            for (int k = 0; k < 2*NPH; k++) sc_sense[k] = ($urandom % 30 == 0);
            if (c == 2000) rst = 1;
            if (c == 2003) rst = 0;
            step();
        end
        finish_run();
    end
endmodule